// File: doc/BRIEF.md
# Streaming Run-Length Sample Compressor

This block turns a stream of 8-channel logic samples, one byte per accepted clock, into a compact byte code and stores that code in a capture memory of fixed size. It keeps the value and length of the run in progress. When a run ends, or its length reaches the largest count a token can carry, it forms a token. A run of any value other than 0xFF becomes three bytes: a run marker, the value and the count. A run of 0xFF becomes two bytes: an escape marker and the count. Because of this, a data byte 0xFF never stands where a marker is expected.

Tokens pass through a small byte queue and go to memory one byte per clock, so sampling never waits on the writes. The capture does not stop after a preset number of samples. It stops when a whole token no longer fits in the memory or in the queue, or when a stop request arrives. After the last byte is written the block raises done. At that point it holds the number of raw samples that the stored tokens represent and the number of bytes written. A one-cycle start pulse clears everything and opens a fresh capture.

Top module: `rle_capture`

## Requirements
- R1: A run of a value V other than 0xFF is stored as three bytes at rising addresses: 0xFF, then V, then the run length.
- R2: A run of the value 0xFF is stored as two bytes: 0xFE, then the run length.
- R3: A run length byte is always between 1 and 253. A 254th equal sample closes a 253 token and opens a new run of the same value with length 1.
- R4: Memory writes carry one byte per cycle. After start they use consecutive addresses from 0, and the address always stays below the memory size.
- R5: Before a token is stored, the block checks that the whole token fits in the remaining memory. If it does not, capture stops, no part of that token is written, and done rises once the queue has drained.
- R6: A stop request ignores any sample in the same cycle. It stores the open run as a last token if that token fits, and raises done after the queue has drained. A stop with no open run stores nothing.
- R7: The byte queue holds 2**FIFO_AW bytes. If a token needs more space than is free in the queue at that cycle (measured before that cycle's write), capture stops exactly as in R5.
- R8: sample_total equals the sum of the run lengths of all stored tokens. byte_count equals the number of bytes written since start.
- R9: A start pulse clears the counters, the queue and the run state. The first sample after start always opens a new run, even if it equals the last value of the previous capture.
- R10: After reset, done, mem_we, sample_total and byte_count are 0. Samples are ignored until a start pulse.
- R11: Cycles with samp_valid low neither lengthen nor end a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the block and begins a capture |
| stop | input | 1 | Request to end the capture and store the open run |
| samp_valid | input | 1 | A sample is present this cycle |
| samp_data | input | 8 | Sample byte, one bit per channel |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | ADDR_W | Capture memory byte address |
| mem_wdata | output | 8 | Byte written to the capture memory |
| done | output | 1 | Capture finished and every byte written |
| sample_total | output | 32 | Raw samples represented by the stored tokens |
| byte_count | output | ADDR_W+1 | Bytes written since start |

## Verification
Two events can meet in one cycle. A run that closes on a differing sample can coincide with a stop request, and a new token can be pushed while the queue is sending a byte to memory. The bench drives a stop in the same cycle as a valid sample of a new value, and only the earlier run may then appear in memory. It also feeds an alternating pattern on every clock. Here the queue fill grows by two bytes per cycle, and the cycle in which a token is refused must follow from the fill measured before that cycle's write. A behavioural model checks every write and the done flag on every clock.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam logic [7:0] RUN_MARK = 8'hFF;
    localparam logic [7:0] ESC_MARK = 8'hFE;
    localparam logic [7:0] MAX_RUN  = 8'd253;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } cap_state_e;

    // bytes[0] is written first
    typedef struct packed {
        logic [1:0]      len;
        logic [2:0][7:0] bytes;
    } token_t;

    function automatic token_t make_token(input logic [7:0] val, input logic [7:0] cnt);
        token_t t;
        if (val == 8'hFF) begin
            t.len      = 2'd2;
            t.bytes[0] = ESC_MARK;
            t.bytes[1] = cnt;
            t.bytes[2] = 8'h00;
        end else begin
            t.len      = 2'd3;
            t.bytes[0] = RUN_MARK;
            t.bytes[1] = val;
            t.bytes[2] = cnt;
        end
        return t;
    endfunction

endpackage

// File: rtl/rle_byte_fifo.sv
module rle_byte_fifo
    import rle_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  token_t        tok,
    output logic [AW:0]   count,
    output logic          nonempty,
    output logic [7:0]    head
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [AW:0]   cnt;
    } fptr_t;

    fptr_t fp_d, fp_q;
    logic [7:0] mem_q [DEPTH];
    logic       pop;

    always_comb begin
        fp_d = fp_q;
        pop  = (fp_q.cnt != '0);
        if (clear) begin
            fp_d = '0;
        end else begin
            if (pop) fp_d.rd = fp_q.rd + 1'b1;
            if (push) fp_d.wr = fp_q.wr + AW'(tok.len);
            fp_d.cnt = fp_q.cnt - (AW+1)'(pop) + (push ? (AW+1)'(tok.len) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fp_q <= '0;
        else        fp_q <= fp_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (push && !clear && (2'(i) < tok.len))
                mem_q[fp_q.wr + AW'(i)] <= tok.bytes[i];
        end
    end

    assign count    = fp_q.cnt;
    assign nonempty = pop;
    assign head     = mem_q[fp_q.rd];

    // queue never holds more than its depth (encoder must respect free space)
    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fp_q.cnt <= (AW+1)'(DEPTH));

endmodule

// File: rtl/rle_mem_port.sv
module rle_mem_port #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W:0]   written
);
    localparam int MEM_BYTES = 1 << ADDR_W;

    logic [ADDR_W:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clear)      addr_d = '0;
        else if (wr_en) addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign mem_we    = wr_en && !clear;
    assign mem_addr  = addr_q[ADDR_W-1:0];
    assign mem_wdata = wr_byte;
    assign written   = addr_q;

    // a write never lands past the end of memory
    p_addr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (addr_q < (ADDR_W+1)'(MEM_BYTES)));

endmodule

// File: rtl/rle_encoder.sv
module rle_encoder
    import rle_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int FIFO_AW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             samp_valid,
    input  logic [7:0]       samp_data,
    input  logic [FIFO_AW:0] fifo_count,
    output logic             push,
    output token_t           tok,
    output cap_state_e       state,
    output logic [31:0]      total
);
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int FIFO_DEPTH = 1 << FIFO_AW;

    typedef struct packed {
        cap_state_e      st;
        logic            have;
        logic [7:0]      val;
        logic [7:0]      cnt;
        logic [ADDR_W:0] res;
        logic [31:0]     total;
    } enc_t;

    enc_t e_d, e_q;
    logic fits;

    always_comb begin
        e_d  = e_q;
        push = 1'b0;
        tok  = make_token(e_q.val, e_q.cnt);
        fits = (({1'b0, e_q.res} + (ADDR_W+2)'(tok.len)) <= (ADDR_W+2)'(MEM_BYTES))
            && (({1'b0, fifo_count} + (FIFO_AW+2)'(tok.len)) <= (FIFO_AW+2)'(FIFO_DEPTH));

        if (start) begin
            e_d    = '0;
            e_d.st = ST_RUN;
        end else begin
            unique case (e_q.st)
                ST_RUN: begin
                    if (stop) begin
                        if (e_q.have && fits) push = 1'b1;
                        e_d.have = 1'b0;
                        e_d.st   = ST_DRAIN;
                    end else if (samp_valid) begin
                        if (!e_q.have) begin
                            e_d.have = 1'b1;
                            e_d.val  = samp_data;
                            e_d.cnt  = 8'd1;
                        end else if (samp_data == e_q.val && e_q.cnt < MAX_RUN) begin
                            e_d.cnt = e_q.cnt + 8'd1;
                        end else if (fits) begin
                            push    = 1'b1;
                            e_d.val = samp_data;
                            e_d.cnt = 8'd1;
                        end else begin
                            e_d.have = 1'b0;
                            e_d.st   = ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (fifo_count == '0) e_d.st = ST_DONE;
                end
                default: ;
            endcase
            if (push) begin
                e_d.res   = e_q.res + (ADDR_W+1)'(tok.len);
                e_d.total = e_q.total + 32'(e_q.cnt);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign state = e_q.st;
    assign total = e_q.total;

    // an open run always carries a legal count byte
    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.have |-> (e_q.cnt >= 8'd1 && e_q.cnt <= MAX_RUN));

    // reserved bytes never exceed the memory
    p_reserve_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.res <= (ADDR_W+1)'(MEM_BYTES));

    // a stop never leaves the block running
    p_stop_leaves_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && e_q.st == ST_RUN) |=> (e_q.st == ST_DRAIN));

endmodule

// File: rtl/rle_capture.sv
module rle_capture
    import rle_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int FIFO_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              samp_valid,
    input  logic [7:0]        samp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic [31:0]       sample_total,
    output logic [ADDR_W:0]   byte_count
);
    logic             push;
    token_t           tok;
    cap_state_e       state;
    logic [FIFO_AW:0] fifo_count;
    logic             fifo_nonempty;
    logic [7:0]       fifo_head;

    rle_encoder #(.ADDR_W(ADDR_W), .FIFO_AW(FIFO_AW)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .fifo_count (fifo_count),
        .push       (push),
        .tok        (tok),
        .state      (state),
        .total      (sample_total)
    );

    rle_byte_fifo #(.AW(FIFO_AW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .push     (push),
        .tok      (tok),
        .count    (fifo_count),
        .nonempty (fifo_nonempty),
        .head     (fifo_head)
    );

    rle_mem_port #(.ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .wr_en     (fifo_nonempty),
        .wr_byte   (fifo_head),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .written   (byte_count)
    );

    assign done = (state == ST_DONE);

    // once done, memory is quiet
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    // start clears both exported counters
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sample_total == 32'd0 && byte_count == '0));

endmodule

// File: tb/tb_rle_capture.sv
module tb_rle_capture;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 6;
    localparam int FIFO_AW = 3;
    localparam int MEMB    = 1 << ADDR_W;
    localparam int FDEPTH  = 1 << FIFO_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, samp_valid = 1'b0;
    logic [7:0] samp_data = 8'h00;
    logic mem_we, done;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [31:0] sample_total;
    logic [ADDR_W:0] byte_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    rle_capture #(.ADDR_W(ADDR_W), .FIFO_AW(FIFO_AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .samp_valid(samp_valid), .samp_data(samp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .sample_total(sample_total), .byte_count(byte_count)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_tag = "R10";

    // behavioural model
    int m_state = 0; // 0 idle, 1 run, 2 drain, 3 done
    bit m_have = 0;
    int m_val = 0, m_cnt = 0, m_res = 0, m_addr = 0;
    longint m_total = 0;
    int q[$];
    int bmem[MEMB];

    task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        check_eq(cur_tag, "mem_we", mem_we, (q.size() > 0));
        if (q.size() > 0 && mem_we) begin
            check_eq(cur_tag, "mem_wdata", mem_wdata, q[0]);
            check_eq(cur_tag, "mem_addr", mem_addr, m_addr % MEMB);
        end
        check_eq(cur_tag, "done", done, (m_state == 3));
        check_eq(cur_tag, "sample_total", sample_total, m_total);
        check_eq(cur_tag, "byte_count", byte_count, m_addr);
        if (mem_we) bmem[mem_addr] = mem_wdata;
    endtask

    function automatic bit m_fits(input int pre);
        int len = (m_val == 255) ? 2 : 3;
        return (m_res + len <= MEMB) && (pre + len <= FDEPTH);
    endfunction

    task automatic m_emit();
        if (m_val == 255) begin
            q.push_back(8'hFE); q.push_back(m_cnt); m_res += 2;
        end else begin
            q.push_back(8'hFF); q.push_back(m_val); q.push_back(m_cnt); m_res += 3;
        end
        m_total += m_cnt;
    endtask

    task automatic model(input bit st, input bit sp, input bit v, input int d);
        int pre = q.size();
        if (st) begin
            m_state = 1; m_have = 0; m_val = 0; m_cnt = 0; m_res = 0;
            m_total = 0; q.delete(); m_addr = 0;
        end else begin
            if (pre > 0) begin void'(q.pop_front()); m_addr++; end
            if (m_state == 1) begin
                if (sp) begin
                    if (m_have && m_fits(pre)) m_emit();
                    m_have = 0; m_state = 2;
                end else if (v) begin
                    if (!m_have) begin m_have = 1; m_val = d; m_cnt = 1; end
                    else if (d == m_val && m_cnt < 253) m_cnt++;
                    else if (m_fits(pre)) begin m_emit(); m_val = d; m_cnt = 1; end
                    else begin m_have = 0; m_state = 2; end
                end
            end else if (m_state == 2) begin
                if (pre == 0) m_state = 3;
            end
        end
    endtask

    task automatic cyc(input bit st, input bit sp, input bit v, input int d);
        compare_now();
        start = st; stop = sp; samp_valid = v; samp_data = 8'(d);
        @(posedge clk);
        model(st, sp, v, d);
        @(negedge clk);
    endtask

    task automatic feed(input int val, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 1, val);
            for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0);
        end
    endtask

    task automatic begin_capture(input string tag);
        cur_tag = tag;
        for (int i = 0; i < MEMB; i++) bmem[i] = -1;
        cyc(1, 0, 0, 0);
    endtask

    task automatic finish_capture(input bit with_stop);
        if (with_stop) cyc(0, 1, 0, 0);
        for (int i = 0; i < 40 && m_state != 3; i++) cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state, samples ignored before start
        cur_tag = "R10";
        check_eq("R10", "done after reset", done, 0);
        check_eq("R10", "mem_we after reset", mem_we, 0);
        check_eq("R10", "byte_count after reset", byte_count, 0);
        feed(8'h33, 5, 0);
        check_eq("R10", "byte_count idle", byte_count, 0);
        check_eq("R10", "sample_total idle", sample_total, 0);

        // R1 R11 R6 R8: non-FF runs with gaps, stop
        begin_capture("R1");
        feed(8'h00, 5, 2);
        feed(8'h41, 3, 1);
        finish_capture(1);
        check_eq("R1", "mem0", bmem[0], 8'hFF);
        check_eq("R1", "mem1", bmem[1], 8'h00);
        check_eq("R11", "mem2 count with gaps", bmem[2], 5);
        check_eq("R1", "mem3", bmem[3], 8'hFF);
        check_eq("R1", "mem4", bmem[4], 8'h41);
        check_eq("R6", "mem5 flushed run", bmem[5], 3);
        check_eq("R8", "total", sample_total, 8);
        check_eq("R8", "bytes", byte_count, 6);
        check_eq("R6", "done", done, 1);

        // R2: escape token for FF runs
        begin_capture("R2");
        feed(8'hFF, 4, 0);
        feed(8'h07, 1, 0);
        finish_capture(1);
        check_eq("R2", "mem0", bmem[0], 8'hFE);
        check_eq("R2", "mem1", bmem[1], 4);
        check_eq("R2", "mem2", bmem[2], 8'hFF);
        check_eq("R2", "mem3", bmem[3], 8'h07);
        check_eq("R2", "mem4", bmem[4], 1);
        check_eq("R2", "bytes", byte_count, 5);

        // R3: saturation at 253
        begin_capture("R3");
        feed(8'h55, 300, 0);
        finish_capture(1);
        check_eq("R3", "first count", bmem[2], 253);
        check_eq("R3", "second marker", bmem[3], 8'hFF);
        check_eq("R3", "second value", bmem[4], 8'h55);
        check_eq("R3", "second count", bmem[5], 47);
        check_eq("R3", "total", sample_total, 300);

        // R9: start clears, equal first sample opens new run
        begin_capture("R9");
        check_eq("R9", "bytes after start", byte_count, 0);
        check_eq("R9", "total after start", sample_total, 0);
        feed(8'h55, 2, 0);
        finish_capture(1);
        check_eq("R9", "count", bmem[2], 2);
        check_eq("R9", "bytes", byte_count, 3);

        // R6: stop with no open run
        begin_capture("R6");
        finish_capture(1);
        check_eq("R6", "empty bytes", byte_count, 0);
        check_eq("R6", "empty done", done, 1);

        // R6: stop coincides with a differing sample
        begin_capture("R6");
        feed(8'h22, 3, 0);
        cyc(0, 1, 1, 8'h33);
        finish_capture(0);
        check_eq("R6", "coincide bytes", byte_count, 3);
        check_eq("R6", "coincide count", bmem[2], 3);
        check_eq("R6", "coincide total", sample_total, 3);

        // R5 R4: memory fills with whole tokens only
        begin_capture("R5");
        for (int k = 0; k < 30; k++) feed(k, 1, 3);
        finish_capture(0);
        check_eq("R5", "bytes at full", byte_count, 63);
        check_eq("R5", "total at full", sample_total, 21);
        check_eq("R5", "last marker", bmem[60], 8'hFF);
        check_eq("R5", "last value", bmem[61], 20);
        check_eq("R4", "no write past token", bmem[63], -1);
        check_eq("R5", "done without stop", done, 1);

        // R7: queue pressure, one sample per clock alternating
        begin_capture("R7");
        for (int k = 0; k < 12; k++) cyc(0, 0, 1, (k % 2) ? 8'h11 : 8'h10);
        finish_capture(0);
        check_eq("R7", "bytes", byte_count, 9);
        check_eq("R7", "total", sample_total, 3);
        check_eq("R7", "mem4", bmem[4], 8'h11);
        check_eq("R7", "mem7", bmem[7], 8'h10);
        check_eq("R7", "done", done, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule